// File: doc/BRIEF.md
# Sample Rate Ratio Meter

The meter reports how fast the output sample rate runs compared with an incoming sample rate. It is clocked by an output master clock that runs at a fixed multiple (by default 256) of the output sample rate. It counts master-clock cycles between consecutive rising edges of an input frame strobe, which arrives already synchronised to that clock. The count is scaled and clamped into an unsigned fixed-point ratio. With the default parameters the ratio is 8 bits wide: bits 7:6 hold the whole part and bits 5:0 hold the fraction in steps of 1/64.

A host reads the ratio as a plain register value and uses the valid flag to decide whether to trust it. The result only has meaning while the lock indication is high. The first partial strobe period after reset, or after lock is gained, only starts a measurement. Each new result replaces the previous one in a single cycle, with no filtering. Cycle jitter on either clock can therefore move the least significant bit from one measurement to the next.

Top module: `srm_ratio_meter`

## Requirements
- R1: While reset is asserted, and after it until the first update, `ratio_o` is 0x00 and `ratio_valid_o` is 0.
- R2: For a period of P master-clock cycles (P < 1024) between two consecutive rising edges of the strobe while locked and armed, `ratio_o` becomes floor(P/4) in the cycle after the second edge. Bits 7:6 of this value are the whole part and bits 5:0 are the fraction in 1/64 units, so P = 256 (equal rates) gives 0x40.
- R3: A measured period of 1024 cycles or more, meaning a ratio above 3 63/64, yields `ratio_o` = 0xFF.
- R4: If no further rising edge arrives, the period counter stops at its limit and does not wrap. At most 1025 cycles after the last captured edge, `ratio_o` reads 0xFF with `ratio_valid_o` high.
- R5: The first rising edge seen while locked, after reset or after lock is gained, changes neither `ratio_o` nor `ratio_valid_o`. It only starts the next measurement.
- R6: When `locked_i` is low, `ratio_valid_o` is 0 from the next cycle on, and strobe edges leave `ratio_o` unchanged.
- R7: Between captures `ratio_o` holds its value. A strobe held high for many cycles causes only the one capture at its rising edge.
- R8: Successive results are not smoothed. Periods of 259, 260 and 259 cycles read 0x40, 0x41 and 0x40 in turn.
- R9: `ratio_valid_o` rises together with the first result of a full period measured while locked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Output master clock (multiple of the output sample rate) |
| rst_n | input | 1 | Active-low asynchronous reset |
| frame_strobe_i | input | 1 | Synchronised input frame strobe; rising edges mark input sample periods |
| locked_i | input | 1 | High while the clock recovery reports lock |
| ratio_o | output | RATIO_W | Output/input rate ratio, whole part in the top RATIO_W-FRAC_W bits |
| ratio_valid_o | output | 1 | High when `ratio_o` holds a measurement taken while locked |

## Verification
The bench builds the meter with its defaults: an 8-bit ratio, 6 fraction bits and a master clock at 256 times the output rate. With these values the saturation limit falls at 1024 cycles. Periods on both sides of that limit, as well as a stopped strobe, therefore fit in a few thousand cycles. The quarter-cycle quantisation step lets periods of 259 and 260 cycles show the unfiltered LSB step, and a wide strobe pulse shows that only edges count.

// File: rtl/srm_pkg.sv
package srm_pkg;

    // Phase of the measurement sequencer
    typedef enum logic [1:0] {
        MTR_WAIT_LOCK = 2'd0,  // not locked: nothing trusted
        MTR_WAIT_EDGE = 2'd1,  // locked, waiting for the arming edge
        MTR_MEASURE   = 2'd2   // a period is being timed
    } mtr_state_e;

endpackage

// File: rtl/srm_edge_detect.sv
module srm_edge_detect (
    input  logic clk,
    input  logic rst_n,
    input  logic level_i,
    output logic rise_o
);

    logic level_d, level_q;

    always_comb begin
        level_d = level_i;
        rise_o  = level_i & ~level_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) level_q <= 1'b0;
        else        level_q <= level_d;
    end

endmodule

// File: rtl/srm_period_counter.sv
module srm_period_counter #(
    parameter int CNT_W = 11,
    parameter logic [CNT_W-1:0] SAT_CNT = CNT_W'(1024)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart_i,
    output logic [CNT_W-1:0] count_o,
    output logic             sat_o
);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        if (restart_i)
            cnt_d = CNT_W'(1);
        else if (cnt_q >= SAT_CNT)
            cnt_d = SAT_CNT;
        else
            cnt_d = cnt_q + CNT_W'(1);
        count_o = cnt_q;
        sat_o   = (cnt_q == SAT_CNT);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= SAT_CNT;
        else        cnt_q <= cnt_d;
    end

    // R4: once at the limit, the counter stays there until a restart
    a_r4_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (sat_o && !restart_i) |=> (count_o == SAT_CNT));

endmodule

// File: rtl/srm_ratio_quant.sv
module srm_ratio_quant #(
    parameter int CNT_W   = 11,
    parameter int RATIO_W = 8,
    parameter int SHIFT   = 2,
    parameter logic [CNT_W-1:0] SAT_CNT = CNT_W'(1024)
) (
    input  logic [CNT_W-1:0]   count_i,
    output logic [RATIO_W-1:0] ratio_o
);

    logic [RATIO_W-1:0] scaled;

    generate
        if (SHIFT > 0) begin : g_shift
            assign scaled = count_i[RATIO_W+SHIFT-1:SHIFT];
        end else begin : g_direct
            assign scaled = count_i[RATIO_W-1:0];
        end
    endgenerate

    always_comb begin
        if (count_i >= SAT_CNT) ratio_o = '1;
        else                    ratio_o = scaled;
    end

endmodule

// File: rtl/srm_ratio_meter.sv
module srm_ratio_meter
    import srm_pkg::*;
#(
    parameter int RATIO_W   = 8,
    parameter int FRAC_W    = 6,
    parameter int MCLK_LOG2 = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               frame_strobe_i,
    input  logic               locked_i,
    output logic [RATIO_W-1:0] ratio_o,
    output logic               ratio_valid_o
);

    localparam int SHIFT = MCLK_LOG2 - FRAC_W;
    localparam int CNT_W = RATIO_W + SHIFT + 1;
    localparam logic [CNT_W-1:0] SAT_CNT = CNT_W'(1) << (RATIO_W + SHIFT);

    typedef struct packed {
        mtr_state_e         st;
        logic [RATIO_W-1:0] ratio;
        logic               valid;
    } meter_t;

    meter_t meter_d, meter_q;

    logic               rise;
    logic [CNT_W-1:0]   period;
    logic               period_sat;
    logic [RATIO_W-1:0] period_ratio;

    srm_edge_detect u_edge (
        .clk     (clk),
        .rst_n   (rst_n),
        .level_i (frame_strobe_i),
        .rise_o  (rise)
    );

    srm_period_counter #(
        .CNT_W   (CNT_W),
        .SAT_CNT (SAT_CNT)
    ) u_count (
        .clk       (clk),
        .rst_n     (rst_n),
        .restart_i (rise),
        .count_o   (period),
        .sat_o     (period_sat)
    );

    srm_ratio_quant #(
        .CNT_W   (CNT_W),
        .RATIO_W (RATIO_W),
        .SHIFT   (SHIFT),
        .SAT_CNT (SAT_CNT)
    ) u_quant (
        .count_i (period),
        .ratio_o (period_ratio)
    );

    always_comb begin
        meter_d = meter_q;
        if (!locked_i) begin
            meter_d.st    = MTR_WAIT_LOCK;
            meter_d.valid = 1'b0;
        end else begin
            unique case (meter_q.st)
                MTR_WAIT_LOCK: meter_d.st = rise ? MTR_MEASURE : MTR_WAIT_EDGE;
                MTR_WAIT_EDGE: if (rise) meter_d.st = MTR_MEASURE;
                MTR_MEASURE: begin
                    if (rise) begin
                        meter_d.ratio = period_ratio;
                        meter_d.valid = 1'b1;
                    end else if (period_sat) begin
                        meter_d.ratio = '1;
                        meter_d.valid = 1'b1;
                    end
                end
                default: meter_d.st = MTR_WAIT_LOCK;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meter_q.st    <= MTR_WAIT_LOCK;
            meter_q.ratio <= '0;
            meter_q.valid <= 1'b0;
        end else begin
            meter_q <= meter_d;
        end
    end

    assign ratio_o       = meter_q.ratio;
    assign ratio_valid_o = meter_q.valid;

    // R6: losing lock clears the valid flag on the next cycle
    a_r6_unlock_clears_valid: assert property (@(posedge clk) disable iff (!rst_n)
        !locked_i |=> !ratio_valid_o);

    // R5: the arming edge leaves the output untouched
    a_r5_arming_edge_silent: assert property (@(posedge clk) disable iff (!rst_n)
        (locked_i && rise && meter_q.st != MTR_MEASURE) |=> $stable(ratio_o));

    // R7: no capture and no saturation means the ratio holds
    a_r7_hold_between: assert property (@(posedge clk) disable iff (!rst_n)
        (!rise && !period_sat) |=> $stable(ratio_o));

    // R3: a long captured period reads as all ones
    a_r3_saturate: assert property (@(posedge clk) disable iff (!rst_n)
        (locked_i && rise && meter_q.st == MTR_MEASURE && period >= SAT_CNT)
        |=> (ratio_o == '1));

    // R9: valid only rises out of a running measurement
    a_r9_valid_after_period: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ratio_valid_o) |-> ($past(meter_q.st) == MTR_MEASURE));

endmodule

// File: tb/srm_ratio_meter_test.sv
module srm_ratio_meter_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       strobe = 1'b0;
    logic       locked = 1'b0;
    logic [7:0] ratio;
    logic       valid;

    int n_checks = 0;
    int n_fail   = 0;

    always #5 clk = ~clk;

    srm_ratio_meter uut (
        .clk            (clk),
        .rst_n          (rst_n),
        .frame_strobe_i (strobe),
        .locked_i       (locked),
        .ratio_o        (ratio),
        .ratio_valid_o  (valid)
    );

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    // Rising edge captured at the posedge after the first negedge; returns
    // after w negedges of high level, strobe low again.
    task automatic send_edge(input int w);
        @(negedge clk) strobe = 1'b1;
        repeat (w) @(negedge clk);
        strobe = 1'b0;
    endtask

    task automatic gap(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Two edges spaced p cycles; the second edge pulse is w cycles wide
    task automatic measure(input int p, input int w, input int exp, input string req);
        send_edge(1);
        gap(p - 2);
        send_edge(w);
        check(req, ratio, exp);
        check(req, valid, 1);
    endtask

    task automatic t_reset;
        gap(3);
        check("R1 ratio in reset", ratio, 8'h00);
        check("R1 valid in reset", valid, 0);
        rst_n = 1'b1;
        gap(2);
        check("R1 ratio after reset", ratio, 8'h00);
        check("R1 valid after reset", valid, 0);
    endtask

    task automatic t_first_period;
        locked = 1'b1;
        gap(2);
        send_edge(1);
        check("R5 arming edge ratio", ratio, 8'h00);
        check("R5 arming edge valid", valid, 0);
        gap(254);
        send_edge(1);
        check("R2 R9 equal rates", ratio, 8'h40);
        check("R9 valid after first period", valid, 1);
    endtask

    task automatic t_ratios;
        measure(512, 1, 8'h80, "R2 period 512");
        measure(100, 1, 8'h19, "R2 period 100");
        measure(700, 1, 8'hAF, "R2 period 700");
        measure(1023, 1, 8'hFF, "R2 period 1023");
    endtask

    task automatic t_jitter;
        measure(259, 1, 8'h40, "R8 period 259");
        measure(260, 1, 8'h41, "R8 period 260");
        measure(259, 1, 8'h40, "R8 period 259 again");
    endtask

    task automatic t_saturate;
        measure(1500, 1, 8'hFF, "R3 period 1500");
        measure(256, 1, 8'h40, "R3 recovery");
        measure(1024, 1, 8'hFF, "R3 period 1024");
    endtask

    task automatic t_level_hold;
        measure(256, 1, 8'h40, "R7 setup");
        measure(300, 250, 8'h4B, "R7 wide pulse");
    endtask

    task automatic t_missing_strobe;
        measure(256, 1, 8'h40, "R4 setup");
        gap(1000);
        check("R4 before limit", ratio, 8'h40);
        gap(30);
        check("R4 stopped strobe ratio", ratio, 8'hFF);
        check("R4 stopped strobe valid", valid, 1);
        gap(3000);
        check("R4 no wrap", ratio, 8'hFF);
    endtask

    task automatic t_lock_loss;
        measure(256, 1, 8'h40, "R6 setup");
        @(negedge clk) locked = 1'b0;
        gap(1);
        check("R6 valid drops", valid, 0);
        send_edge(1);
        gap(510);
        send_edge(1);
        check("R6 ratio ignores edges", ratio, 8'h40);
        check("R6 valid stays low", valid, 0);
        @(negedge clk) locked = 1'b1;
        send_edge(1);
        check("R5 relock arming ratio", ratio, 8'h40);
        check("R5 relock arming valid", valid, 0);
        gap(510);
        send_edge(1);
        check("R9 relock result", ratio, 8'h80);
        check("R9 relock valid", valid, 1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        t_reset();
        t_first_period();
        t_ratios();
        t_jitter();
        t_saturate();
        t_level_hold();
        t_missing_strobe();
        t_lock_loss();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule